// File: doc/BRIEF.md
# Sampling Converter Control and Read-Out Interface

This block is the digital front of a 14-bit sampling converter. It decodes a start request from the chip-select and start-convert pins. Whether chip select takes part in that decode depends on a synchronous/asynchronous mode pin. Once a conversion is accepted, the block runs it for a fixed number of clocks, which stands in for the analog conversion engine. It reports progress on an end-of-convert flag and on a sample-hold indicator.

When the conversion finishes, the 14-bit result is latched left justified into a 16-bit word, with the two lowest bits zero. The word is then read over an 8-bit bus, one byte at a time, with a byte-select pin. Bus drive enables are produced for both the data bus and the status flag. A system integrator uses these enables to build tri-state or open-drain pads outside the block.

After reset, the block's internal logic is busy for a parameterised number of cycles and refuses any start request. An error flag records the case where start-convert is still held low when a conversion completes, which is the unsupported continuous-conversion pattern.

Top module: `convif_top`

## Requirements
- R1: After reset, `eoc_o` is 1, `hold_o` is 0 and `err_o` is 0. For the first BOOT_CYC cycles after reset, no start request is accepted.
- R2: With `mode_sync_i`=1, a high-to-low transition of `start_n_i` starts a conversion only if `cs_n_i` is 0 in that cycle. With `cs_n_i`=1, the transition is ignored.
- R3: With `mode_sync_i`=0, a high-to-low transition of `start_n_i` starts a conversion whatever the value of `cs_n_i`.
- R4: In the cycle after an accepted start, `eoc_o` is 0 and `hold_o` is 1. `eoc_o` then stays 0 for exactly CONV_CYC cycles and returns to 1 on the cycle the result is latched.
- R5: `hold_o` stays 1 for exactly HOLD_CYC cycles (HOLD_CYC < CONV_CYC) and then returns to 0 while `eoc_o` is still 0.
- R6: At completion, `result_i` is latched as word = {result, 2'b00}. With `hi_sel_i`=1, `data_o` shows word[15:8]. With `hi_sel_i`=0, `data_o` shows word[7:0].
- R7: `data_oe_o` is 1 exactly when `cs_n_i`=0 and `oe_n_i`=0.
- R8: With `mode_sync_i`=1, `eoc_oe_o` is 1 exactly when `stat_en_n_i`=0 and `cs_n_i`=0. With `mode_sync_i`=0, it is 1 exactly when `stat_en_n_i`=0.
- R9: A start request that arrives while a conversion is running is ignored. The running conversion still lasts exactly CONV_CYC cycles.
- R10: `err_o` becomes 1 when `start_n_i` is 0 in the completion cycle. It returns to 0 on the next accepted start.
- R11: Holding `start_n_i` at 0 never starts another conversion. A new start needs a fresh high-to-low transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sync_i | input | 1 | 1 = synchronous decode, 0 = asynchronous decode |
| cs_n_i | input | 1 | Chip select, active low |
| start_n_i | input | 1 | Start convert, falling transition requests a conversion |
| oe_n_i | input | 1 | Output enable for data bus, active low |
| stat_en_n_i | input | 1 | Enable for the end-of-convert flag drive, active low |
| hi_sel_i | input | 1 | 1 = high byte on bus, 0 = low byte |
| result_i | input | 14 | Result from the conversion engine |
| eoc_o | output | 1 | 1 = not converting, 0 = conversion in progress |
| eoc_oe_o | output | 1 | Drive enable for eoc_o |
| hold_o | output | 1 | 1 = sample-hold in hold, 0 = track |
| err_o | output | 1 | Start-convert still low at completion |
| data_o | output | 8 | Selected byte of the latched word |
| data_oe_o | output | 1 | Drive enable for data_o |

## Verification
Two things can fall in the same cycle: the completion of a conversion and a start-convert level that is still low. This is provoked by holding start low for a whole conversion. The check is that `err_o` rises while `eoc_o` returns high, and that no new conversion follows until start is released and lowered again. A second collision is a fresh start transition arriving in the middle of a running conversion. Here the check is that the count of low `eoc_o` cycles is still exactly CONV_CYC and that the latched bytes match the first conversion's result.

// File: rtl/convif_pkg.sv
package convif_pkg;
    localparam int RES_W  = 14;
    localparam int WORD_W = 16;
    localparam int BUS_W  = 8;
    localparam int PAD_W  = WORD_W - RES_W;
    localparam int NLANE  = WORD_W / BUS_W;

    typedef enum logic {
        MODE_ASYNC = 1'b0,
        MODE_SYNC  = 1'b1
    } mode_e;
endpackage

// File: rtl/convif_boot.sv
module convif_boot #(
    parameter int BOOT_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic boot_busy_o
);
    localparam int BW = $clog2(BOOT_CYC + 2);

    typedef struct packed {
        logic [BW-1:0] cnt;
    } boot_t;

    boot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != BW'(BOOT_CYC))
            st_d.cnt = st_q.cnt + BW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign boot_busy_o = (st_q.cnt != BW'(BOOT_CYC));

    // once ready, the block never falls back into the busy window
    p_boot_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_busy_o |=> !boot_busy_o);
endmodule

// File: rtl/convif_seq.sv
module convif_seq
    import convif_pkg::*;
#(
    parameter int CONV_CYC = 100,
    parameter int HOLD_CYC = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_busy_i,
    input  logic             sync_i,
    input  logic             cs_n_i,
    input  logic             start_n_i,
    input  logic [RES_W-1:0] result_i,
    output logic             busy_o,
    output logic             hold_o,
    output logic             err_o,
    output logic [RES_W-1:0] res_o
);
    localparam int CW = $clog2(CONV_CYC + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(CONV_CYC - 1);
    localparam logic [CW-1:0] HOLD_END = CW'(HOLD_CYC - 1);

    typedef struct packed {
        logic             busy;
        logic             hold;
        logic             err;
        logic             start_q;
        logic [CW-1:0]    cnt;
        logic [RES_W-1:0] res;
    } seq_t;

    seq_t st_d, st_q;
    logic fall_edge;
    logic start_req;

    always_comb begin
        fall_edge = st_q.start_q & ~start_n_i;
        start_req = fall_edge & ((mode_e'(sync_i) == MODE_SYNC) ? ~cs_n_i : 1'b1);

        st_d         = st_q;
        st_d.start_q = start_n_i;

        if (!st_q.busy) begin
            if (start_req && !boot_busy_i) begin
                st_d.busy = 1'b1;
                st_d.hold = 1'b1;
                st_d.err  = 1'b0;
                st_d.cnt  = '0;
            end
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
            if (st_q.cnt == HOLD_END)
                st_d.hold = 1'b0;
            if (st_q.cnt == LAST_CNT) begin
                st_d.busy = 1'b0;
                st_d.hold = 1'b0;
                st_d.cnt  = '0;
                st_d.res  = result_i;
                st_d.err  = ~start_n_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.start_q <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign hold_o = st_q.hold;
    assign err_o  = st_q.err;
    assign res_o  = st_q.res;

    // accepted request enters hold with conversion running
    p_start_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !boot_busy_i && start_req) |=> (st_q.busy && st_q.hold));

    // running conversion counts on, untouched by new requests
    p_run_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != LAST_CNT) |=> (st_q.busy && st_q.cnt == $past(st_q.cnt) + CW'(1)));

    // hold only inside a conversion
    p_hold_in_conv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hold |-> st_q.busy);

    // boot window blocks every start
    p_boot_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_busy_i && !st_q.busy) |=> !st_q.busy);

    // a fresh conversion begins with the error cleared
    p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> !st_q.err);

    // a level held low cannot open a conversion
    p_need_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !st_q.start_q) |=> !st_q.busy);
endmodule

// File: rtl/convif_port.sv
module convif_port
    import convif_pkg::*;
(
    input  logic             sync_i,
    input  logic             cs_n_i,
    input  logic             oe_n_i,
    input  logic             stat_en_n_i,
    input  logic             hi_sel_i,
    input  logic             busy_i,
    input  logic [RES_W-1:0] res_i,
    output logic [BUS_W-1:0] data_o,
    output logic             data_oe_o,
    output logic             eoc_o,
    output logic             eoc_oe_o
);
    logic [WORD_W-1:0] word;
    logic [BUS_W-1:0]  lane [NLANE];

    assign word = {res_i, {PAD_W{1'b0}}};

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        assign lane[l] = word[l*BUS_W +: BUS_W];
    end

    always_comb begin
        data_o    = hi_sel_i ? lane[NLANE-1] : lane[0];
        data_oe_o = ~cs_n_i & ~oe_n_i;
        eoc_o     = ~busy_i;
        if (mode_e'(sync_i) == MODE_SYNC)
            eoc_oe_o = ~stat_en_n_i & ~cs_n_i;
        else
            eoc_oe_o = ~stat_en_n_i;
    end

    // low byte always carries the zero padding of the left-justified word
    always_comb begin
        if (!hi_sel_i)
            p_low_pad_r6: assert (data_o[PAD_W-1:0] == '0);
    end
endmodule

// File: rtl/convif_top.sv
module convif_top
    import convif_pkg::*;
#(
    parameter int CONV_CYC = 100,
    parameter int HOLD_CYC = 20,
    parameter int BOOT_CYC = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_sync_i,
    input  logic        cs_n_i,
    input  logic        start_n_i,
    input  logic        oe_n_i,
    input  logic        stat_en_n_i,
    input  logic        hi_sel_i,
    input  logic [13:0] result_i,
    output logic        eoc_o,
    output logic        eoc_oe_o,
    output logic        hold_o,
    output logic        err_o,
    output logic [7:0]  data_o,
    output logic        data_oe_o
);
    logic             boot_busy;
    logic             busy;
    logic [RES_W-1:0] res;

    convif_boot #(.BOOT_CYC(BOOT_CYC)) u_boot (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_busy_o (boot_busy)
    );

    convif_seq #(.CONV_CYC(CONV_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_busy_i (boot_busy),
        .sync_i      (mode_sync_i),
        .cs_n_i      (cs_n_i),
        .start_n_i   (start_n_i),
        .result_i    (result_i),
        .busy_o      (busy),
        .hold_o      (hold_o),
        .err_o       (err_o),
        .res_o       (res)
    );

    convif_port u_port (
        .sync_i      (mode_sync_i),
        .cs_n_i      (cs_n_i),
        .oe_n_i      (oe_n_i),
        .stat_en_n_i (stat_en_n_i),
        .hi_sel_i    (hi_sel_i),
        .busy_i      (busy),
        .res_i       (res),
        .data_o      (data_o),
        .data_oe_o   (data_oe_o),
        .eoc_o       (eoc_o),
        .eoc_oe_o    (eoc_oe_o)
    );

    // status flag and sample-hold agree: hold never shows without conversion
    p_eoc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> !eoc_o);
endmodule

// File: tb/test_convif_top.sv
module test_convif_top;
    localparam int CONV = 100;
    localparam int HOLD = 20;
    localparam int BOOT = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_sync = 1'b1, cs_n = 1'b1, start_n = 1'b1, oe_n = 1'b1;
    logic stat_en_n = 1'b1, hi_sel = 1'b1;
    logic [13:0] result = '0;
    logic eoc, eoc_oe, hold, err, data_oe;
    logic [7:0] data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    convif_top #(.CONV_CYC(CONV), .HOLD_CYC(HOLD), .BOOT_CYC(BOOT)) i_convif_top (
        .clk(clk), .rst_n(rst_n), .mode_sync_i(mode_sync), .cs_n_i(cs_n),
        .start_n_i(start_n), .oe_n_i(oe_n), .stat_en_n_i(stat_en_n),
        .hi_sel_i(hi_sel), .result_i(result), .eoc_o(eoc), .eoc_oe_o(eoc_oe),
        .hold_o(hold), .err_o(err), .data_o(data), .data_oe_o(data_oe)
    );

    // {sync, cs_n, oe_n, stat_en_n, expected data_oe, expected eoc_oe}
    localparam logic [5:0] DECODE [8] = '{
        6'b1000_11, 6'b1100_00, 6'b1010_01, 6'b1001_10,
        6'b0100_01, 6'b0001_10, 6'b0111_00, 6'b0010_01
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // start with a falling edge, count eoc-low and hold-high cycles
    task automatic run_conv(input logic sync, input logic cs, input logic [13:0] res,
                            input int glitch, input bit keep_low,
                            output int lo, output int hd);
        @(negedge clk);
        mode_sync = sync; cs_n = cs; result = res; start_n = 1'b0;
        lo = 0; hd = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (eoc == 1'b0) lo++;
            if (hold) hd++;
            if (!keep_low) start_n = (i == glitch) ? 1'b0 : 1'b1;
            if (eoc == 1'b1) break;
        end
    endtask

    task automatic read_bytes(input string tag, input logic [13:0] res);
        logic [15:0] w;
        w = {res, 2'b00};
        cs_n = 1'b0; oe_n = 1'b0; hi_sel = 1'b1;
        #1 check({tag, " high byte"}, data, w[15:8]);
        check({tag, " bus enable R7"}, data_oe, 1);
        hi_sel = 1'b0;
        #1 check({tag, " low byte"}, data, w[7:0]);
        oe_n = 1'b1; cs_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        int lo, hd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 eoc after reset", eoc, 1);
        check("R1 hold after reset", hold, 0);
        check("R1 err after reset", err, 0);

        // start during boot window: ignored
        cs_n = 1'b0;
        run_conv(1'b1, 1'b0, 14'h1234, -1, 0, lo, hd);
        check("R1 start in boot ignored", lo, 0);
        repeat (BOOT + 5) @(negedge clk);

        // decode table
        foreach (DECODE[k]) begin
            mode_sync = DECODE[k][5]; cs_n = DECODE[k][4];
            oe_n = DECODE[k][3]; stat_en_n = DECODE[k][2];
            #1;
            check($sformatf("R7 data_oe row %0d", k), data_oe, DECODE[k][1]);
            check($sformatf("R8 eoc_oe row %0d", k), eoc_oe, DECODE[k][0]);
            check("R4 idle eoc", eoc, 1);
            @(negedge clk);
        end
        cs_n = 1'b1; oe_n = 1'b1; stat_en_n = 1'b1;
        @(negedge clk);

        // synchronous start with chip select low
        run_conv(1'b1, 1'b0, 14'h2D5B, -1, 0, lo, hd);
        check("R2/R4 sync conversion length", lo, CONV);
        check("R5 hold length", hd, HOLD);
        check("R5 hold back to track", hold, 0);
        read_bytes("R6 sync", 14'h2D5B);

        // synchronous start with chip select high: ignored
        run_conv(1'b1, 1'b1, 14'h0AAA, -1, 0, lo, hd);
        check("R2 sync cs high ignored", lo, 0);
        read_bytes("R2 result unchanged R6", 14'h2D5B);

        // asynchronous start regardless of chip select
        run_conv(1'b0, 1'b1, 14'h3FFF, -1, 0, lo, hd);
        check("R3 async conversion length", lo, CONV);
        read_bytes("R3 async R6", 14'h3FFF);

        // second falling edge mid conversion
        run_conv(1'b1, 1'b0, 14'h0155, 30, 0, lo, hd);
        check("R9 length with mid request", lo, CONV);
        check("R9 err after clean end", err, 0);
        read_bytes("R9 result", 14'h0155);

        // start held low through completion
        run_conv(1'b1, 1'b0, 14'h2001, -1, 1, lo, hd);
        check("R10 held-low length", lo, CONV);
        check("R10 err raised", err, 1);
        repeat (10) @(negedge clk);
        check("R11 held low no restart", eoc, 1);
        @(negedge clk);
        start_n = 1'b1;
        @(negedge clk);
        run_conv(1'b1, 1'b0, 14'h0000, -1, 0, lo, hd);
        check("R10 conversion after release", lo, CONV);
        check("R10 err cleared", err, 0);
        read_bytes("R6 zero result", 14'h0000);

        finished = 1;
        summary();
    end
endmodule